// File: doc/BRIEF.md
# Traffic Generator Address Sequencer

This block supplies the start address of every transaction issued by one stream of a memory traffic generator. A command is loaded with a lower bound, an upper bound, a first address, a step value, a burst length and a mode selector. After that the sequencer offers one address at a time on a valid/ready port. Each accepted address is consumed, and the next one is computed.

Two families of modes exist. The stepping modes walk upward from the first address, by a programmed step or by the byte size of each burst. When the upper bound is reached, they fall back to the lower bound. The pseudo-random modes take their address from a 32-bit linear feedback shift register that is seeded from the step value. The result can be shaped so that it lands on a 32-byte boundary or deliberately off one. In some random modes it is also bounded to the configured window.

Top module: `tg_addr_sequencer`

## Requirements
- R1: After reset `addrValid` is 0 and stays 0 until the first `cmdLoad`. From the cycle after a `cmdLoad` it is 1, and it remains 1.
- R2: `cmdLoad` captures all `cfg*` inputs. In stepping modes the first offered address equals `cfgStart`. A `cmdLoad` that coincides with an accepted handshake takes precedence, and the handshake has no effect.
- R3: Mode 0 (stepped) works as follows. After an accepted address A, the next address is `cfgBase` when A >= `cfgHigh`, and A + `cfgStep` otherwise.
- R4: Mode 1 (burst-stepped) uses the same wrap rule as R3. The step is (`cfgBeats` + 1) * 32 bytes.
- R5: While `addrValid` is 1 and `addrReady` is 0, with no `cmdLoad`, `addrOut` holds its value.
- R6: The generator is a 32-bit shift register that shifts left. The bit entering at position 0 is the XOR of bits 31, 21, 1 and 0. It is loaded with the low 32 bits of `cfgStep`, and a zero value is replaced by 1. It advances once per accepted address in every mode. Mode 2 offers the register value unmodified.
- R7: Mode 3 offers the register value with address bits [4:0] cleared.
- R8: Mode 4 offers the register value, but when bits [4:0] are all zero, bit 0 is set. Bits [4:0] are therefore never zero.
- R9: Mode 5 offers `cfgBase` + (register mod (`cfgHigh` - `cfgBase`)). When `cfgHigh` equals `cfgBase`, it offers `cfgBase`.
- R10: Mode 6 first clears bits [4:0] of the mode-5 value. If the result is below `cfgBase`, 32 is added. If it is then above `cfgHigh`, `cfgBase` is offered instead.
- R11: Mode 7 takes the mode-5 value and sets bit 0 when bits [4:0] are zero, unless `cfgHigh` equals `cfgBase`. In modes 5 to 7, with `cfgBase` <= `cfgHigh`, every address lies within [`cfgBase`, `cfgHigh`].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdLoad | input | 1 | Load a new command from the cfg inputs |
| cfgMode | input | 3 | Address mode 0..7 |
| cfgBase | input | ADDR_W | Lower bound of the address window |
| cfgHigh | input | ADDR_W | Upper bound of the address window |
| cfgStart | input | ADDR_W | First address in stepping modes |
| cfgStep | input | ADDR_W | Step in mode 0, seed in random modes |
| cfgBeats | input | LEN_W | Burst length minus one |
| addrReady | input | 1 | Consumer accepts the offered address |
| addrValid | output | 1 | An address is on offer |
| addrOut | output | ADDR_W | Offered transaction start address |

## Verification
Two events can fall in the same cycle: a new command load and the acceptance of the current address. The bench provokes this by issuing each later command while `addrReady` is high and an address is already on offer. It then checks that the first address after the load is the new start address or the new seed's value, with no extra step applied. A behavioural model of all eight modes is compared with the outputs every cycle. The ready pattern stalls regularly, so hold behaviour and wrap to the lower bound are also observed in cycles of their own.

// File: rtl/tgas_pkg.sv
package tgas_pkg;
  localparam int LFSR_W     = 32;
  localparam int ALIGN_BITS = 5;

  typedef enum logic [2:0] {
    MODE_LINEAR    = 3'd0,
    MODE_AUTO      = 3'd1,
    MODE_RAND      = 3'd2,
    MODE_RAND_AL   = 3'd3,
    MODE_RAND_UNAL = 3'd4,
    MODE_UNIF      = 3'd5,
    MODE_UNIF_AL   = 3'd6,
    MODE_UNIF_UNAL = 3'd7
  } addrMode_e;

  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;
endpackage

// File: rtl/tgas_ctrl.sv
module tgas_ctrl
  import tgas_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdLoad,
  input  logic       addrReady,
  output seqStrobe_t strobe,
  output logic       addrValid
);
  logic active;

  always_ff @(posedge clk) begin
    if (!rstN)        active <= 1'b0;
    else if (cmdLoad) active <= 1'b1;
  end

  assign addrValid      = active;
  assign strobe.load    = cmdLoad;
  assign strobe.advance = active & addrReady & ~cmdLoad;

  // R1: a load always produces an offer on the next cycle
  a_r1_valid_after_load: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoad |=> addrValid);
  // R1: once offering, the port keeps offering
  a_r1_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> addrValid);
endmodule

// File: rtl/tgas_datapath.sv
module tgas_datapath
  import tgas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              addrValid,
  input  logic [2:0]        cfgMode,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgHigh,
  input  logic [ADDR_W-1:0] cfgStart,
  input  logic [ADDR_W-1:0] cfgStep,
  input  logic [LEN_W-1:0]  cfgBeats,
  output logic [ADDR_W-1:0] addrOut
);
  localparam logic [ADDR_W-1:0] LOW_MASK   = ADDR_W'((1 << ALIGN_BITS) - 1);
  localparam logic [ADDR_W-1:0] ALIGN_STEP = ADDR_W'(1 << ALIGN_BITS);

  addrMode_e         modeQ;
  logic [ADDR_W-1:0] baseQ, highQ, stepQ, curQ;
  logic [LEN_W-1:0]  beatsQ;
  logic [LFSR_W-1:0] lfsrQ, lfsrNext, seedVal;

  logic [ADDR_W-1:0] prbsAddr, autoStep, linStep, curNext, span;
  logic [ADDR_W-1:0] uniOffset, uniRaw, uniAl, uniUnal, randAl, randUnal;

  // PRBS: left shift, feedback from bits 31, 21, 1, 0
  assign lfsrNext = {lfsrQ[LFSR_W-2:0], lfsrQ[31] ^ lfsrQ[21] ^ lfsrQ[1] ^ lfsrQ[0]};
  assign seedVal  = (LFSR_W'(cfgStep) == '0) ? LFSR_W'(1) : LFSR_W'(cfgStep);
  assign prbsAddr = ADDR_W'(lfsrQ);

  // Linear stepping with wrap to base
  assign autoStep = (ADDR_W'(beatsQ) + ADDR_W'(1)) << ALIGN_BITS;
  assign linStep  = (modeQ == MODE_AUTO) ? autoStep : stepQ;
  assign curNext  = (curQ >= highQ) ? baseQ : curQ + linStep;

  // Random shaping
  assign randAl   = prbsAddr & ~LOW_MASK;
  assign randUnal = ((prbsAddr & LOW_MASK) == '0) ? (prbsAddr | ADDR_W'(1)) : prbsAddr;

  // Uniform bounding, then alignment shaping, then clamp
  assign span      = highQ - baseQ;
  assign uniOffset = (span == '0) ? '0 : prbsAddr % span;
  assign uniRaw    = baseQ + uniOffset;
  assign uniUnal   = ((span != '0) && ((uniRaw & LOW_MASK) == '0)) ? (uniRaw | ADDR_W'(1)) : uniRaw;

  always_comb begin
    uniAl = uniRaw & ~LOW_MASK;
    if (uniAl < baseQ) uniAl = uniAl + ALIGN_STEP;
    if (uniAl > highQ) uniAl = baseQ;
  end

  always_comb begin
    unique case (modeQ)
      MODE_LINEAR, MODE_AUTO: addrOut = curQ;
      MODE_RAND:              addrOut = prbsAddr;
      MODE_RAND_AL:           addrOut = randAl;
      MODE_RAND_UNAL:         addrOut = randUnal;
      MODE_UNIF:              addrOut = uniRaw;
      MODE_UNIF_AL:           addrOut = uniAl;
      MODE_UNIF_UNAL:         addrOut = uniUnal;
      default:                addrOut = curQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_LINEAR;
      baseQ  <= '0;
      highQ  <= '0;
      stepQ  <= '0;
      beatsQ <= '0;
      curQ   <= '0;
      lfsrQ  <= LFSR_W'(1);
    end else if (strobe.load) begin
      modeQ  <= addrMode_e'(cfgMode);
      baseQ  <= cfgBase;
      highQ  <= cfgHigh;
      stepQ  <= cfgStep;
      beatsQ <= cfgBeats;
      curQ   <= cfgStart;
      lfsrQ  <= seedVal;
    end else if (strobe.advance) begin
      curQ   <= curNext;
      lfsrQ  <= lfsrNext;
    end
  end

  // R6: the generator never locks up in the all-zero state
  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
  // R3: stepping past the upper bound returns to the lower bound
  a_r3_wrap_to_base: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && modeQ == MODE_LINEAR && curQ >= highQ) |=> curQ == baseQ);
  // R5: offered address holds while the consumer stalls
  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !strobe.advance && !strobe.load) |=> $stable(addrOut));
  // R7: aligned random addresses sit on a 32-byte boundary
  a_r7_rand_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && modeQ == MODE_RAND_AL) |-> addrOut[ALIGN_BITS-1:0] == '0);
  // R8: unaligned random addresses never sit on a boundary
  a_r8_rand_unaligned: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && modeQ == MODE_RAND_UNAL) |-> addrOut[ALIGN_BITS-1:0] != '0);
  // R11: uniform modes stay inside the window
  a_r11_uniform_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && modeQ >= MODE_UNIF && baseQ <= highQ) |-> (addrOut >= baseQ && addrOut <= highQ));
endmodule

// File: rtl/tg_addr_sequencer.sv
module tg_addr_sequencer
  import tgas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdLoad,
  input  logic [2:0]        cfgMode,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgHigh,
  input  logic [ADDR_W-1:0] cfgStart,
  input  logic [ADDR_W-1:0] cfgStep,
  input  logic [LEN_W-1:0]  cfgBeats,
  input  logic              addrReady,
  output logic              addrValid,
  output logic [ADDR_W-1:0] addrOut
);
  seqStrobe_t strobe;

  tgas_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmdLoad   (cmdLoad),
    .addrReady (addrReady),
    .strobe    (strobe),
    .addrValid (addrValid)
  );

  tgas_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addrValid (addrValid),
    .cfgMode   (cfgMode),
    .cfgBase   (cfgBase),
    .cfgHigh   (cfgHigh),
    .cfgStart  (cfgStart),
    .cfgStep   (cfgStep),
    .cfgBeats  (cfgBeats),
    .addrOut   (addrOut)
  );
endmodule

// File: tb/tg_addr_sequencer_tb_top.sv
`timescale 1ns/1ps
module tg_addr_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdLoad = 1'b0;
  logic [2:0]  cfgMode = '0;
  logic [31:0] cfgBase = '0, cfgHigh = '0, cfgStart = '0, cfgStep = '0;
  logic [3:0]  cfgBeats = '0;
  logic        addrReady = 1'b0;
  logic        addrValid;
  logic [31:0] addrOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  bit          mActive = 0;
  bit          mFirst = 0;
  bit          mStall = 0;
  int          mMode = 0;
  longint      mBase, mHigh, mStep, mCur, mBeats;
  logic [31:0] mLfsr = 32'd1;

  always #4 clk = ~clk;

  tg_addr_sequencer dut_i (
    .clk(clk), .rstN(rstN), .cmdLoad(cmdLoad), .cfgMode(cfgMode),
    .cfgBase(cfgBase), .cfgHigh(cfgHigh), .cfgStart(cfgStart), .cfgStep(cfgStep),
    .cfgBeats(cfgBeats), .addrReady(addrReady), .addrValid(addrValid), .addrOut(addrOut)
  );

  function automatic logic [31:0] prbsStep(input logic [31:0] s);
    logic [31:0] tapMask = (32'h1 << 31) | (32'h1 << 21) | 32'h2 | 32'h1;
    return {s[30:0], ^(s & tapMask)};
  endfunction

  function automatic longint expAddr();
    longint r = longint'(mLfsr);
    longint span = mHigh - mBase;
    longint u, a;
    u = (span == 0) ? mBase : mBase + (r % span);
    case (mMode)
      0, 1: return mCur;
      2: return r;
      3: return r - (r % 32);
      4: return ((r % 32) == 0) ? r + 1 : r;
      5: return u;
      6: begin
        a = u - (u % 32);
        if (a < mBase) a = a + 32;
        if (a > mHigh) a = mBase;
        return a;
      end
      default: return (span != 0 && (u % 32) == 0) ? u + 1 : u;
    endcase
  endfunction

  function automatic string modeTag(input int m);
    case (m)
      0: return "R3"; 1: return "R4"; 2: return "R6"; 3: return "R7";
      4: return "R8"; 5: return "R9"; 6: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One cycle: check at negedge, drive, update model across the posedge.
  task automatic cyc(input bit ld, input bit rdy, input int md, input longint b,
                     input longint h, input longint st, input longint sp, input int bt);
    string tag;
    longint e;
    check("R1 valid", longint'(addrValid), longint'(mActive));
    if (mActive) begin
      tag = mFirst ? "R2" : (mStall ? "R5" : modeTag(mMode));
      e = expAddr();
      check(tag, longint'(addrOut), e & 64'hFFFF_FFFF);
    end
    cmdLoad = ld; addrReady = rdy;
    if (ld) begin
      cfgMode = 3'(md); cfgBase = 32'(b); cfgHigh = 32'(h);
      cfgStart = 32'(st); cfgStep = 32'(sp); cfgBeats = 4'(bt);
    end
    mFirst = 0; mStall = 0;
    if (ld) begin
      mActive = 1; mFirst = 1; mMode = md; mBase = b; mHigh = h;
      mStep = (md == 1) ? (longint'(bt) + 1) * 32 : sp;
      mBeats = bt; mCur = st;
      mLfsr = (sp[31:0] == 0) ? 32'd1 : sp[31:0];
    end else if (mActive && rdy) begin
      mCur = (mCur >= mHigh) ? mBase : mCur + mStep;
      mLfsr = prbsStep(mLfsr);
    end else if (mActive) begin
      mStall = 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runCmd(input int md, input longint b, input longint h,
                        input longint st, input longint sp, input int bt, input int n);
    cyc(1, 1, md, b, h, st, sp, bt);
    for (int i = 0; i < n; i++) cyc(0, (i % 4) != 2, md, b, h, st, sp, bt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: no offer before a load, even with ready high
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0);
    runCmd(0, 'h100, 'h180, 'h100, 'h40, 0, 12);    // R3 wrap exactly at high
    runCmd(0, 'h100, 'h1A0, 'h150, 'h20, 0, 12);    // R3 mid start; load during handshake R2
    runCmd(1, 'h2000, 'h2100, 'h2000, 0, 1, 14);    // R4 64-byte bursts
    runCmd(1, 'h0, 'h400, 'h3E0, 0, 15, 10);        // R4 512-byte bursts
    runCmd(2, 0, 0, 0, 0, 0, 20);                   // R6 zero seed
    runCmd(2, 0, 0, 0, 'hACE1, 0, 20);              // R6
    runCmd(3, 0, 0, 0, 'h1234_5678, 0, 30);         // R7
    runCmd(4, 0, 0, 0, 'h8000_0000, 0, 30);         // R8
    runCmd(5, 'h1000, 'h1F00, 0, 'h55AA, 0, 30);    // R9
    runCmd(5, 'h3000, 'h3000, 0, 'h77, 0, 6);       // R9 empty window
    runCmd(6, 'h1010, 'h1100, 0, 'h9E37, 0, 30);    // R10 unaligned base
    runCmd(6, 'h1010, 'h1018, 0, 'h0F0F, 0, 10);    // R10 window with no boundary
    runCmd(6, 'h4000, 'h8000, 0, 'h2468, 0, 20);    // R10
    runCmd(7, 'h1000, 'h1400, 0, 'h1, 0, 30);       // R11
    runCmd(7, 'h3003, 'h3003, 0, 'h3, 0, 6);        // R11 empty window
    // R5: long stall in a random mode
    cyc(1, 1, 2, 0, 0, 0, 'hBEEF, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 2, 0, 0, 0, 0, 0);
    cyc(0, 1, 2, 0, 0, 0, 0, 0);
    cyc(0, 0, 2, 0, 0, 0, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule